// File: doc/BRIEF.md
# Video Control-Change Synchronizer

This block sits inline on a packetized video stream and inspects every control packet, the packet that announces the format of the frames that follow it. It extracts the frame width from each control packet and compares it with the width from the previous control packet. When the width has changed and triggering is enabled, the block issues a programmed list of register writes on a memory-mapped master port. These writes reconfigure a downstream processing stage, for example by setting its output width, so that the new setting applies to the first frame that carries the new format.

The comparison follows what actually arrives on the stream and ignores software timing. An upstream frame buffer that drops or repeats frames therefore cannot cause a spurious or a missed reconfiguration. While the writes are outstanding, the stream is stalled in the middle of the triggering control packet. As a result, neither the rest of that packet nor any later video reaches the downstream stage before its registers are updated. Software programs the enable bit, the write count and the address/data list through a small memory-mapped slave port. A build-time option makes each trigger one-shot: the enable bit clears itself after every trigger.

Top module: `vidCtrlSync`

## Requirements
- R1: While no master write is pending, outValid equals inValid, outData/outSop/outEop equal their inputs, and inReady equals outReady, all in the same cycle.
- R2: The first control packet after reset stores its width as the reference and issues no write. The stored width reads back in bits 31:16 of slave register 0.
- R3: A control packet is a packet whose first beat (inSop high) carries 0xF in data bits 3:0. Its width is carried in bits 3:0 of the next four beats, most significant nibble first. A packet whose first-beat type is 0 is video and never affects the width or the trigger.
- R4: A control packet whose width equals the stored reference issues no master write.
- R5: A changed width with the enable bit set issues exactly `count` writes, one for each list entry, in index order 0, 1, 2, and so on. Entry i has its address at slave address 8+i and its data at slave address 16+i.
- R6: A changed width with the enable bit clear issues no write but still updates the stored reference width.
- R7: mWrite stays high and mAddr/mWdata stay unchanged while mWaitreq is high. The block moves to the next entry only on a cycle in which mWaitreq is low.
- R8: While any master write is pending, inReady and outValid are low, and bit 1 (busy) of slave register 0 reads 1.
- R9: With ONE_SHOT=1, the enable bit (bit 0 of slave register 0) reads 0 after a trigger, and a later width change issues no write until software sets the bit again.
- R10: The count register at slave address 1 reads back the value written, clamped to the list depth of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input stream beat valid |
| inReady | output | 1 | Input stream ready |
| inData | input | 8 | Input beat data |
| inSop | input | 1 | First beat of a packet |
| inEop | input | 1 | Last beat of a packet |
| outValid | output | 1 | Output stream beat valid |
| outReady | input | 1 | Output stream ready |
| outData | output | 8 | Output beat data |
| outSop | output | 1 | Output first beat |
| outEop | output | 1 | Output last beat |
| sAddr | input | 5 | Slave register address |
| sWrite | input | 1 | Slave write strobe |
| sWdata | input | 32 | Slave write data |
| sRdata | output | 32 | Slave read data, combinational from sAddr |
| mWrite | output | 1 | Master write request |
| mAddr | output | 16 | Master write address |
| mWdata | output | 32 | Master write data |
| mWaitreq | input | 1 | Master wait request |

## Verification
The assertions assume that software does not change the count register while a write burst is in flight. They also assume that a software write to register 0 never lands in the same cycle as a trigger. The bench reprograms the count and the enable bit only between packets, after the stalled packet has been fully accepted. The assertions further assume that the stream obeys valid/ready rules, holding each beat until it is accepted. The bench drives beats that way, and it toggles mWaitreq in a fixed repeating pattern so that every burst meets stalls.

// File: rtl/vcsPkg.sv
package vcsPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // store newW as the reference width
    logic fire;     // trigger accepted, starts a burst
  } vcsStrobe_t;
endpackage

// File: rtl/vcsCtrl.sv
module vcsCtrl
  import vcsPkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inSop,
  input  logic [3:0]    inNib,
  input  logic          outReady,
  input  logic          enable,
  input  logic [CW-1:0] count,
  input  logic [15:0]   refW,
  input  logic          haveRef,
  input  logic          mWaitreq,
  output logic          inReady,
  output logic          outValid,
  output vcsStrobe_t    strobe,
  output logic [15:0]   newW,
  output logic          busy,
  output logic [IW-1:0] idx
);
  logic       accepted, isCtrl, widthBeat;
  logic [3:0] beatCnt;
  logic [11:0] widthSh;

  assign inReady  = outReady && !busy;
  assign outValid = inValid && !busy;
  assign accepted = inValid && inReady;

  // packet parser: beat counter and width nibble collector
  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatCnt <= '0;
      isCtrl  <= 1'b0;
      widthSh <= '0;
    end else if (accepted) begin
      if (inSop) begin
        beatCnt <= 4'd1;
        isCtrl  <= (inNib == 4'hF);
      end else if (beatCnt != 4'd15) begin
        beatCnt <= beatCnt + 4'd1;
      end
      if (!inSop && isCtrl && beatCnt >= 4'd1 && beatCnt <= 4'd3)
        widthSh <= {widthSh[7:0], inNib};
    end
  end

  assign widthBeat = accepted && !inSop && isCtrl && (beatCnt == 4'd4);
  assign newW = {widthSh, inNib};

  always_comb begin
    strobe.capture = widthBeat && (!haveRef || newW != refW);
    strobe.fire    = widthBeat && haveRef && (newW != refW) && enable;
  end

  // write sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (strobe.fire && count != '0) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy && !mWaitreq) begin
      if ({1'b0, idx} == count - CW'(1)) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + IW'(1);
      end
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && mWaitreq) |=> (busy && idx == $past(idx)));
  assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ({1'b0, idx} < count));
  assert_start_on_width_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(widthBeat && enable));
endmodule

// File: rtl/vcsData.sv
module vcsData
  import vcsPkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW = 16,
  parameter int MDW = 32,
  parameter bit ONE_SHOT = 1'b0,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int SAW = IW + 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [SAW-1:0] sAddr,
  input  logic           sWrite,
  input  logic [31:0]    sWdata,
  output logic [31:0]    sRdata,
  input  vcsStrobe_t     strobe,
  input  logic [15:0]    newW,
  input  logic           busy,
  input  logic [IW-1:0]  idx,
  output logic           enable,
  output logic [CW-1:0]  count,
  output logic [15:0]    refW,
  output logic           haveRef,
  output logic [AW-1:0]  mAddr,
  output logic [MDW-1:0] mWdata
);
  logic [AW-1:0]  addrMem [DEPTH];
  logic [MDW-1:0] dataMem [DEPTH];
  logic [1:0]     region;
  logic [IW-1:0]  sel;
  logic           ctrlWr;

  assign region = sAddr[SAW-1 -: 2];
  assign sel    = sAddr[IW-1:0];
  assign ctrlWr = sWrite && region == 2'd0 && sel == '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable  <= 1'b0;
      count   <= '0;
      refW    <= '0;
      haveRef <= 1'b0;
    end else begin
      if (ctrlWr) enable <= sWdata[0];
      else if (ONE_SHOT && strobe.fire) enable <= 1'b0;
      if (sWrite && region == 2'd0 && sel == IW'(1))
        count <= (sWdata > 32'(DEPTH)) ? CW'(DEPTH) : sWdata[CW-1:0];
      if (strobe.capture) begin
        refW    <= newW;
        haveRef <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrMem[i] <= '0;
        dataMem[i] <= '0;
      end else if (sWrite && sel == IW'(i)) begin
        if (region == 2'd1) addrMem[i] <= sWdata[AW-1:0];
        if (region == 2'd2) dataMem[i] <= sWdata[MDW-1:0];
      end
    end
  end

  always_comb begin
    case (region)
      2'd0:    sRdata = (sel == '0) ? {refW, 14'd0, busy, enable}
                      : (sel == IW'(1)) ? 32'(count) : 32'd0;
      2'd1:    sRdata = 32'(addrMem[sel]);
      2'd2:    sRdata = 32'(dataMem[sel]);
      default: sRdata = 32'd0;
    endcase
  end

  assign mAddr  = addrMem[idx];
  assign mWdata = dataMem[idx];

  assert_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && $stable(idx)) |-> ($stable(mAddr) && $stable(mWdata)));
  assert_count_max_R10: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  if (ONE_SHOT) begin : g_oneShot
    assert_disarm_R9: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.fire && !ctrlWr) |=> !enable);
  end
endmodule

// File: rtl/vidCtrlSync.sv
module vidCtrlSync
  import vcsPkg::*;
#(
  parameter int DW = 8,
  parameter int DEPTH = 8,
  parameter int AW = 16,
  parameter int MDW = 32,
  parameter bit ONE_SHOT = 1'b0,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int SAW = IW + 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  output logic           inReady,
  input  logic [DW-1:0]  inData,
  input  logic           inSop,
  input  logic           inEop,
  output logic           outValid,
  input  logic           outReady,
  output logic [DW-1:0]  outData,
  output logic           outSop,
  output logic           outEop,
  input  logic [SAW-1:0] sAddr,
  input  logic           sWrite,
  input  logic [31:0]    sWdata,
  output logic [31:0]    sRdata,
  output logic           mWrite,
  output logic [AW-1:0]  mAddr,
  output logic [MDW-1:0] mWdata,
  input  logic           mWaitreq
);
  vcsStrobe_t    strobe;
  logic [15:0]   newW, refW;
  logic          busy, enable, haveRef;
  logic [IW-1:0] idx;
  logic [CW-1:0] count;

  assign outData = inData;
  assign outSop  = inSop;
  assign outEop  = inEop;
  assign mWrite  = busy;

  vcsCtrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk, .rstN, .inValid, .inSop, .inNib(inData[3:0]), .outReady,
    .enable, .count, .refW, .haveRef, .mWaitreq,
    .inReady, .outValid, .strobe, .newW, .busy, .idx
  );

  vcsData #(.DEPTH(DEPTH), .AW(AW), .MDW(MDW), .ONE_SHOT(ONE_SHOT)) u_data (
    .clk, .rstN, .sAddr, .sWrite, .sWdata, .sRdata,
    .strobe, .newW, .busy, .idx,
    .enable, .count, .refW, .haveRef, .mAddr, .mWdata
  );
endmodule

// File: tb/vidCtrlSync_tb.sv
module vidCtrlSync_tb;
  logic clk = 0, rstN = 0;
  logic inValid = 0, inSop = 0, inEop = 0, outReady = 1, sWrite = 0, mWaitreq = 0;
  logic [7:0] inData = 0;
  logic [4:0] sAddr = 0;
  logic [31:0] sWdata = 0;
  wire inReady, outValid, outSop, outEop, mWrite;
  wire [7:0] outData;
  wire [31:0] sRdata, mWdata;
  wire [15:0] mAddr;

  int total = 0, bad = 0, cyc = 0;
  int logCnt = 0, orderErr = 0, passErr = 0, stallSeen = 0, holdErr = 0;
  logic [15:0] prevA; logic prevStall = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  vidCtrlSync #(.ONE_SHOT(1'b1)) u_dut (.*);

  function automatic logic [15:0] expA(int j); return 16'h0100 + 16'(j); endfunction
  function automatic logic [31:0] expD(int j); return 32'hC0DE0000 + 32'(j * 17); endfunction

  // waitrequest pattern, write log and stream monitors
  always @(negedge clk) begin
    cyc++;
    mWaitreq = (cyc % 4 == 1) || (cyc % 4 == 2);
    #1;
    if (prevStall && mWrite && mAddr != prevA) holdErr++;   // R7
    prevStall = mWrite && mWaitreq; prevA = mAddr;
    if (mWrite && !mWaitreq) begin
      if (mAddr != expA(logCnt) || mWdata != expD(logCnt)) orderErr++;
      logCnt++;
    end
    if (!mWrite) begin
      if (outValid != inValid || outData != inData || outSop != inSop ||
          outEop != inEop || inReady != outReady) passErr++;
    end else begin
      if (inReady || outValid) passErr++;
      if (inValid) stallSeen++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic slvWr(input int a, input logic [31:0] d);
    @(negedge clk); sAddr = 5'(a); sWdata = d; sWrite = 1;
    @(negedge clk); sWrite = 0;
  endtask

  task automatic slvRd(input int a, output logic [31:0] d);
    @(negedge clk); sAddr = 5'(a); #2; d = sRdata;
  endtask

  task automatic beat(input logic s, input logic e, input logic [7:0] d);
    @(negedge clk); inValid = 1; inSop = s; inEop = e; inData = d;
    #2; while (!inReady) begin @(negedge clk); #2; end
    @(posedge clk);
  endtask

  task automatic idleStream();
    @(negedge clk); inValid = 0; inSop = 0; inEop = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendCtrl(input logic [15:0] w, input logic [15:0] h);
    beat(1, 0, 8'h0F);
    for (int k = 3; k >= 0; k--) beat(0, 0, {4'hA, w[k*4 +: 4]});
    for (int k = 3; k >= 0; k--) beat(0, k == 0, {4'h5, h[k*4 +: 4]});
    idleStream();
  endtask

  task automatic sendVideo();
    beat(1, 0, 8'h00);
    for (int k = 0; k < 6; k++) beat(0, k == 5, 8'hFF);
    idleStream();
  endtask

  initial begin
    #1500000;
    chk(0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    slvRd(0, rv); chk(rv == 0, "R2 reset reg0", rv, 0);
    chk(mWrite == 0, "R8 reset idle", mWrite, 0);
    for (int j = 0; j < 8; j++) begin slvWr(8 + j, 32'(expA(j))); slvWr(16 + j, expD(j)); end
    slvRd(8 + 5, rv); chk(rv == 32'(expA(5)), "R5 entry addr readback", rv, expA(5));
    slvWr(1, 12); slvRd(1, rv); chk(rv == 8, "R10 count clamp", rv, 8);
    slvWr(1, 3); slvRd(1, rv); chk(rv == 3, "R10 count readback", rv, 3);
    slvWr(0, 1);

    logCnt = 0; sendCtrl(16'd640, 16'd480);
    chk(logCnt == 0, "R2 first packet no write", logCnt, 0);
    slvRd(0, rv); chk(rv[31:16] == 640, "R2 stored width", rv[31:16], 640);
    chk(rv[0] == 1, "R9 still armed", rv[0], 1);

    sendVideo();
    chk(logCnt == 0, "R3 video ignored", logCnt, 0);
    slvRd(0, rv); chk(rv[31:16] == 640, "R3 width after video", rv[31:16], 640);

    sendCtrl(16'd640, 16'd240);
    chk(logCnt == 0, "R4 unchanged width", logCnt, 0);

    sendCtrl(16'd320, 16'd240);
    chk(logCnt == 3, "R5 burst length", logCnt, 3);
    chk(stallSeen > 0, "R8 stall observed", stallSeen, 1);
    slvRd(0, rv); chk(rv[0] == 0, "R9 disarmed", rv[0], 0);
    chk(rv[31:16] == 320, "R5 new width", rv[31:16], 320);
    chk(rv[1] == 0, "R8 busy clear", rv[1], 0);

    logCnt = 0; sendCtrl(16'd800, 16'd600);
    chk(logCnt == 0, "R6/R9 disabled no write", logCnt, 0);
    slvRd(0, rv); chk(rv[31:16] == 800, "R6 width tracked", rv[31:16], 800);

    for (int k = 1; k <= 8; k++) begin
      slvWr(1, k); slvWr(0, 1); logCnt = 0;
      sendCtrl(16'(1000 + k * 37), 16'd100);
      chk(logCnt == k, "R5 sweep count", logCnt, k);
    end
    chk(orderErr == 0, "R5 order", orderErr, 0);
    chk(holdErr == 0, "R7 hold under waitreq", holdErr, 0);
    chk(passErr == 0, "R1/R8 pass-through", passErr, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule